// File: doc/BRIEF.md
# Field-Masked Condition Register Unit

This block keeps a 32-bit condition word split into eight 4-bit fields, plus a small fixed-point exception word holding summary-overflow, overflow and carry flags and a 5-bit byte count. The condition word is read in full through a combinational port. It is written through a masked port: an 8-bit select picks which fields take the matching nibble of the write data, and all other fields keep their contents.

The exception word has a full-word read and a full-word write. A separate one-bit carry port lets an execution unit change only the carry flag. When that port and a full write land in the same cycle, the carry port decides the carry value. All updates happen on the rising clock edge. Both reads are combinational views of the stored state.

Top module: `cond_state_unit`

## Requirements
- R1: A synchronous active-high reset clears every condition field and every exception flag, so both read words are zero on the cycle after reset.
- R2: Condition field i (i = 0..7) is presented on read bits [31-4i : 28-4i]. Field 0 is therefore bits 31:28 and field 7 is bits 3:0.
- R3: With the write enable high, field i is loaded on the next edge from write-data bits [31-4i : 28-4i] when mask bit (7 - i) is set. Mask bit 7 selects field 0.
- R4: A field whose mask bit is clear, and every field while the write enable is low, keeps its previous value.
- R5: A full exception write, with no carry update in the same cycle, loads summary overflow from data bit 31, overflow from bit 30, carry from bit 29 and the byte count from bits 4:0. The read word shows each one at the same position.
- R6: Exception read bits 28:5 are always zero, whatever was written.
- R7: A carry update loads the carry flag (read bit 29) from the carry value input on the next edge. Without a full write in the same cycle, it leaves the other exception bits unchanged.
- R8: When a full exception write and a carry update occur in the same cycle, the carry flag takes the carry-update value. The other exception fields still come from the full write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cr_wr_en | input | 1 | Masked condition-word write strobe |
| cr_wr_mask | input | 8 | Field select, bit 7 selects field 0 |
| cr_wr_data | input | 32 | Condition write data, nibble per field |
| cr_rd_data | output | 32 | Combinational condition word |
| xr_wr_en | input | 1 | Full exception-word write strobe |
| xr_wr_data | input | 32 | Exception write data |
| ca_upd_en | input | 1 | Carry-only update strobe |
| ca_upd_val | input | 1 | New carry value |
| xr_rd_data | output | 32 | Combinational exception word |

## Verification
The assertions check on every cycle the effect of the previous edge on each field (loaded when selected, held otherwise), the always-zero gap in the exception word, the carry port's control of bit 29 and the held flags around it, and the reset clear. The field-to-bit placement of the read word, the full-word result of mixed mask patterns, and the ordering under simultaneous writes are shown by the bench's scenarios. In those scenarios a behavioural model predicts both read words on every clock, through walking single-field masks, empty and full masks, random masks and a reset applied mid-run.

// File: rtl/cond_state_pkg.sv
package cond_state_pkg;

    localparam int CR_FIELDS  = 8;
    localparam int FIELD_W    = 4;
    localparam int WORD_W     = CR_FIELDS * FIELD_W;
    localparam int BCNT_W     = 5;
    localparam int XR_SO_POS  = 31;
    localparam int XR_OV_POS  = 30;
    localparam int XR_CA_POS  = 29;

    typedef logic [FIELD_W-1:0] cr_field_t;
    typedef logic [WORD_W-1:0]  word_t;

    typedef struct packed {
        logic              so;
        logic              ov;
        logic              ca;
        logic [BCNT_W-1:0] bcnt;
    } xr_state_t;

    // Lowest bit of field idx inside the condition word (field 0 is the top nibble)
    function automatic int field_lsb(input int idx);
        return WORD_W - FIELD_W * (idx + 1);
    endfunction

    function automatic xr_state_t xr_unpack(input word_t w);
        xr_state_t s;
        s.so   = w[XR_SO_POS];
        s.ov   = w[XR_OV_POS];
        s.ca   = w[XR_CA_POS];
        s.bcnt = w[BCNT_W-1:0];
        return s;
    endfunction

    function automatic word_t xr_pack(input xr_state_t s);
        word_t w;
        w             = '0;
        w[XR_SO_POS]  = s.so;
        w[XR_OV_POS]  = s.ov;
        w[XR_CA_POS]  = s.ca;
        w[BCNT_W-1:0] = s.bcnt;
        return w;
    endfunction

endpackage

// File: rtl/cond_field_bank.sv
module cond_field_bank
    import cond_state_pkg::*;
#(
    parameter int NUM_FIELDS = CR_FIELDS,
    parameter int FLD_W      = FIELD_W,
    localparam int DW        = NUM_FIELDS * FLD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [NUM_FIELDS-1:0] wr_mask,
    input  logic [DW-1:0]         wr_data,
    output logic [DW-1:0]         rd_data
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
            localparam int LSB = DW - FLD_W * (gi + 1);
            logic [FLD_W-1:0] fld_q;
            logic             fld_sel;

            // mask bit (NUM_FIELDS-1-i) owns field i
            assign fld_sel = wr_en & wr_mask[NUM_FIELDS-1-gi];

            always_ff @(posedge clk) begin
                if (rst) begin
                    fld_q <= '0;
                end else if (fld_sel) begin
                    fld_q <= wr_data[LSB +: FLD_W];
                end
            end

            assign rd_data[LSB +: FLD_W] = fld_q;
        end
    endgenerate

endmodule

// File: rtl/xr_flag_reg.sv
module xr_flag_reg
    import cond_state_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  word_t     wr_data,
    input  logic      ca_en,
    input  logic      ca_val,
    output xr_state_t state
);

    xr_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            if (wr_en) begin
                state_q <= xr_unpack(wr_data);
            end
            // later assignment gives the carry port priority
            if (ca_en) begin
                state_q.ca <= ca_val;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/cond_state_unit.sv
module cond_state_unit
    import cond_state_pkg::*;
#(
    parameter int NUM_FIELDS = CR_FIELDS,
    parameter int FLD_W      = FIELD_W,
    localparam int DW        = NUM_FIELDS * FLD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cr_wr_en,
    input  logic [NUM_FIELDS-1:0] cr_wr_mask,
    input  logic [DW-1:0]         cr_wr_data,
    output logic [DW-1:0]         cr_rd_data,
    input  logic                  xr_wr_en,
    input  logic [WORD_W-1:0]     xr_wr_data,
    input  logic                  ca_upd_en,
    input  logic                  ca_upd_val,
    output logic [WORD_W-1:0]     xr_rd_data
);

    xr_state_t xr_state;

    cond_field_bank #(
        .NUM_FIELDS (NUM_FIELDS),
        .FLD_W      (FLD_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cr_wr_en),
        .wr_mask (cr_wr_mask),
        .wr_data (cr_wr_data),
        .rd_data (cr_rd_data)
    );

    xr_flag_reg u_xr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (xr_wr_en),
        .wr_data (xr_wr_data),
        .ca_en   (ca_upd_en),
        .ca_val  (ca_upd_val),
        .state   (xr_state)
    );

    assign xr_rd_data = xr_pack(xr_state);

endmodule

// File: rtl/cond_state_chk.sv
module cond_state_chk
    import cond_state_pkg::*;
#(
    parameter int NUM_FIELDS = CR_FIELDS,
    parameter int FLD_W      = FIELD_W,
    localparam int DW        = NUM_FIELDS * FLD_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cr_wr_en,
    input logic [NUM_FIELDS-1:0] cr_wr_mask,
    input logic [DW-1:0]         cr_wr_data,
    input logic [DW-1:0]         cr_rd_data,
    input logic                  xr_wr_en,
    input logic [WORD_W-1:0]     xr_wr_data,
    input logic                  ca_upd_en,
    input logic                  ca_upd_val,
    input logic [WORD_W-1:0]     xr_rd_data
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cr_rd_data == '0 && xr_rd_data == '0));

    // R6
    xr_gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        xr_rd_data[XR_CA_POS-1:BCNT_W] == '0);

    // R7
    ca_port_chk: assert property (@(posedge clk) disable iff (rst)
        ca_upd_en |=> xr_rd_data[XR_CA_POS] == $past(ca_upd_val));

    // R7
    ca_others_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ca_upd_en && !xr_wr_en) |=>
            ($stable(xr_rd_data[XR_SO_POS:XR_OV_POS]) && $stable(xr_rd_data[BCNT_W-1:0])));

    // R5
    xr_full_write_chk: assert property (@(posedge clk) disable iff (rst)
        (xr_wr_en && !ca_upd_en) |=>
            (xr_rd_data[XR_SO_POS:XR_CA_POS] == $past(xr_wr_data[XR_SO_POS:XR_CA_POS]) &&
             xr_rd_data[BCNT_W-1:0] == $past(xr_wr_data[BCNT_W-1:0])));

    // R8
    xr_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (xr_wr_en && ca_upd_en) |=>
            (xr_rd_data[XR_CA_POS] == $past(ca_upd_val) &&
             xr_rd_data[XR_SO_POS:XR_OV_POS] == $past(xr_wr_data[XR_SO_POS:XR_OV_POS])));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_fchk
            localparam int LSB = DW - FLD_W * (gi + 1);

            // R3
            field_load_chk: assert property (@(posedge clk) disable iff (rst)
                (cr_wr_en && cr_wr_mask[NUM_FIELDS-1-gi]) |=>
                    cr_rd_data[LSB +: FLD_W] == $past(cr_wr_data[LSB +: FLD_W]));

            // R4
            field_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !(cr_wr_en && cr_wr_mask[NUM_FIELDS-1-gi]) |=>
                    $stable(cr_rd_data[LSB +: FLD_W]));
        end
    endgenerate

endmodule

bind cond_state_unit cond_state_chk #(
    .NUM_FIELDS (NUM_FIELDS),
    .FLD_W      (FLD_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cr_wr_en   (cr_wr_en),
    .cr_wr_mask (cr_wr_mask),
    .cr_wr_data (cr_wr_data),
    .cr_rd_data (cr_rd_data),
    .xr_wr_en   (xr_wr_en),
    .xr_wr_data (xr_wr_data),
    .ca_upd_en  (ca_upd_en),
    .ca_upd_val (ca_upd_val),
    .xr_rd_data (xr_rd_data)
);

// File: tb/test_cond_state_unit.sv
module test_cond_state_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        cr_wr_en;
    logic [7:0]  cr_wr_mask;
    logic [31:0] cr_wr_data;
    logic [31:0] cr_rd_data;
    logic        xr_wr_en;
    logic [31:0] xr_wr_data;
    logic        ca_upd_en;
    logic        ca_upd_val;
    logic [31:0] xr_rd_data;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string req    = "R1";

    // behavioural reference state
    logic [3:0] m_fld [8];
    bit         m_so, m_ov, m_ca;
    logic [4:0] m_bc;

    always #5 clk = ~clk;

    cond_state_unit i_cond_state_unit (
        .clk        (clk),
        .rst        (rst),
        .cr_wr_en   (cr_wr_en),
        .cr_wr_mask (cr_wr_mask),
        .cr_wr_data (cr_wr_data),
        .cr_rd_data (cr_rd_data),
        .xr_wr_en   (xr_wr_en),
        .xr_wr_data (xr_wr_data),
        .ca_upd_en  (ca_upd_en),
        .ca_upd_val (ca_upd_val),
        .xr_rd_data (xr_rd_data)
    );

    function automatic logic [31:0] exp_cr();
        logic [31:0] w = '0;
        for (int i = 0; i < 8; i++) w = w | (32'(m_fld[i]) << (28 - 4 * i));
        return w;
    endfunction

    function automatic logic [31:0] exp_xr();
        return {m_so, m_ov, m_ca, 24'd0, m_bc};
    endfunction

    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < 8; i++) m_fld[i] = 4'h0;
            m_so = 0; m_ov = 0; m_ca = 0; m_bc = '0;
        end else begin
            if (cr_wr_en)
                for (int i = 0; i < 8; i++)
                    if (cr_wr_mask[7 - i]) m_fld[i] = cr_wr_data[31 - 4 * i -: 4];
            if (xr_wr_en) begin
                m_so = xr_wr_data[31]; m_ov = xr_wr_data[30];
                m_ca = xr_wr_data[29]; m_bc = xr_wr_data[4:0];
            end
            if (ca_upd_en) m_ca = ca_upd_val;
        end
    endtask

    task automatic compare();
        checks++;
        if (cr_rd_data !== exp_cr()) begin
            errors++;
            $display("FAIL %s cond word actual %h expected %h", req, cr_rd_data, exp_cr());
        end
        checks++;
        if (xr_rd_data !== exp_xr()) begin
            errors++;
            $display("FAIL %s exception word actual %h expected %h", req, xr_rd_data, exp_xr());
        end
    endtask

    // one clock: model follows the edge, outputs compared on the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        cr_wr_en = 0; xr_wr_en = 0; ca_upd_en = 0;
    endtask

    initial begin
        rst = 1; idle();
        cr_wr_mask = '0; cr_wr_data = '0; xr_wr_data = '0; ca_upd_val = 0;
        @(negedge clk);
        // R1 reset state
        req = "R1";
        step(); step();
        rst = 0;

        // R3 R2 full mask write, distinct nibbles locate every field
        req = "R2";
        cr_wr_en = 1; cr_wr_mask = 8'hFF; cr_wr_data = 32'h1234_5678;
        step(); idle(); step();

        // R3 walking single-field select, bit 7 picks field 0
        req = "R3";
        for (int k = 7; k >= 0; k--) begin
            cr_wr_en = 1; cr_wr_mask = 8'(1 << k); cr_wr_data = 32'hFEDC_BA98 ^ 32'(k);
            step();
        end
        idle(); step();

        // R4 empty mask and disabled write with full mask
        req = "R4";
        cr_wr_en = 1; cr_wr_mask = 8'h00; cr_wr_data = 32'h0;
        step();
        cr_wr_en = 0; cr_wr_mask = 8'hFF; cr_wr_data = 32'hAAAA_5555;
        step(); step();

        // R3 R4 random mixed masks
        req = "R4";
        for (int n = 0; n < 60; n++) begin
            cr_wr_en = 1'($urandom); cr_wr_mask = 8'($urandom); cr_wr_data = $urandom;
            step();
        end
        idle(); step();

        // R5 R6 full exception writes including the gap bits
        req = "R6";
        xr_wr_en = 1; xr_wr_data = 32'hFFFF_FFFF;
        step();
        req = "R5";
        xr_wr_data = 32'h4000_0013; step();
        xr_wr_data = 32'hA000_0000; step();
        xr_wr_data = 32'h2000_001F; step();
        idle(); step();

        // R7 carry-only updates
        req = "R7";
        ca_upd_en = 1; ca_upd_val = 0; step();
        ca_upd_val = 1; step();
        idle(); step();

        // R8 simultaneous full write and carry update
        req = "R8";
        xr_wr_en = 1; xr_wr_data = 32'hE000_0005; ca_upd_en = 1; ca_upd_val = 0;
        step();
        xr_wr_data = 32'h0000_0000; ca_upd_val = 1;
        step();
        idle(); step();

        // random mix across both ports
        req = "R8";
        for (int n = 0; n < 60; n++) begin
            cr_wr_en = 1'($urandom); cr_wr_mask = 8'($urandom); cr_wr_data = $urandom;
            xr_wr_en = 1'($urandom); xr_wr_data = $urandom;
            ca_upd_en = 1'($urandom); ca_upd_val = 1'($urandom);
            step();
        end

        // R1 reset applied mid-run while writes are requested
        req = "R1";
        cr_wr_en = 1; cr_wr_mask = 8'hFF; cr_wr_data = 32'hDEAD_BEEF;
        xr_wr_en = 1; xr_wr_data = 32'hFFFF_FFFF; ca_upd_en = 1; ca_upd_val = 1;
        rst = 1;
        step();
        rst = 0; idle();
        step();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule